// File: doc/BRIEF.md
# UART Break Sequence Generator

This block sits beside a UART transmitter and, once a stop request arrives, forces the serial output low for a programmed number of whole break characters. A break character is a full character time of zero bits. Its length in bits is set by the frame format in use. It is one start bit, the data bits (5 to 14), an optional parity bit and one or two stop bits. With 8 data bits, no parity and one stop bit that comes to 10 bits.

The normal transmitter's serial output passes through the block unchanged while no break is being sent. A stop request that arrives while that transmitter is still shifting a character waits until the character has finished. `tx_hold` tells the transmitter not to start another character. The break itself starts on a bit-rate strobe.

When the last break character is complete, the line goes back to idle high for one full bit time. A single-cycle `brk_done` pulse then marks the end. All timing is counted in bit-rate strobes.

The block has no data stream of its own. Every pin is a plain control or status level or pulse, so no valid/ready back-pressure applies.

Top module: `brk_seq_tx`

## Requirements
- R1: After reset, `tx_line` equals `tx_data_in` (idle high), and `tx_hold`, `brk_active` and `brk_done` are all low.
- R2: A `stop_req` accepted with a nonzero break count drives `tx_line` low for exactly count × L bit-rate strobe periods. The low period starts on a `bit_tick` edge. During it, `brk_active` and `tx_hold` are high.
- R3: The character length L is 1 + D + P + S. D is `data_len` clamped to the range 5..14. P is 1 when `parity_en` is high. S is 2 when `two_stop` is high, and 1 otherwise.
- R4: If `tx_busy` is high when a stop is accepted, or later, the following hold while it stays high: `tx_hold` is high, `brk_active` is low and `tx_line` keeps following `tx_data_in`. The break begins on the first `bit_tick` with `tx_busy` low.
- R5: A stop accepted with a break count of 0 never drives the line low. It raises `brk_done` for exactly one cycle, in the cycle after the request.
- R6: After the last break character, `tx_line` is high for exactly one bit period. `brk_done` then pulses for one cycle, and `tx_hold` and `brk_active` fall in the same cycle.
- R7: The frame format and the break count are sampled when the stop is accepted. Changing them afterwards has no effect on the sequence that is running.
- R8: A `stop_req` that arrives while a sequence is pending or running is ignored. It does not lengthen the break and does not produce a second `brk_done`.
- R9: The bit and character counters advance only on `bit_tick`. The low time therefore scales with the strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| stop_req | input | 1 | Stop-transmit request pulse; starts a break sequence when idle |
| tx_busy | input | 1 | The normal transmitter is shifting a character |
| tx_data_in | input | 1 | Serial output of the normal transmitter |
| data_len | input | 4 | Number of data bits per character (clamped to 5..14) |
| parity_en | input | 1 | The frame carries a parity bit |
| two_stop | input | 1 | The frame uses two stop bits |
| brk_count | input | 16 | Number of break characters to send |
| tx_line | output | 1 | Serial line output |
| tx_hold | output | 1 | Tells the normal transmitter not to start a new character |
| brk_active | output | 1 | A break or its trailing idle bit is in progress |
| brk_done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The bench drives a regular `bit_tick` with a period of P cycles and samples on the falling clock edge. Each output change lands one rising edge after the cause, so a break's low run measures exactly count × L × P falling-edge samples. The rise of `brk_done` follows the line's return to high by exactly P samples. A zero-count stop shows `brk_done` on the first falling edge after the request and clears it on the next. The bench therefore compares exact sample counts rather than windows, and it runs one case with a different strobe period to show that the timing follows the strobe.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BREAK = 2'd2,
    ST_GUARD = 2'd3
  } brk_state_e;
endpackage

// File: rtl/brk_frame_len.sv
// Character length in bits from the frame format, with data length clamped.
module brk_frame_len #(
  parameter int DLEN_W   = 4,
  parameter int MIN_DLEN = 5,
  parameter int MAX_DLEN = 14,
  parameter int LEN_W    = 5
) (
  input  logic [DLEN_W-1:0] data_len,
  input  logic              parity_en,
  input  logic              two_stop,
  output logic [LEN_W-1:0]  char_len
);
  logic [DLEN_W-1:0] d_eff;
  logic [LEN_W-1:0]  stop_bits;

  always_comb begin
    if (data_len < DLEN_W'(MIN_DLEN))      d_eff = DLEN_W'(MIN_DLEN);
    else if (data_len > DLEN_W'(MAX_DLEN)) d_eff = DLEN_W'(MAX_DLEN);
    else                                   d_eff = data_len;
    stop_bits = two_stop ? LEN_W'(2) : LEN_W'(1);
    char_len  = LEN_W'(1) + LEN_W'(d_eff) + LEN_W'(parity_en) + stop_bits;
  end
endmodule

// File: rtl/brk_bit_timer.sv
// Counts bit positions inside one break character; advances on the strobe only.
module brk_bit_timer #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] char_len,
  output logic             char_end
);
  logic [LEN_W-1:0] bit_cnt;

  assign char_end = run && tick && (bit_cnt == char_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bit_cnt <= '0;
    else if (!run)     bit_cnt <= '0;
    else if (tick)     bit_cnt <= char_end ? '0 : bit_cnt + LEN_W'(1);
  end

  // R9: no movement without a strobe
  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bit_cnt));
  // R3: position never reaches the character length
  a_r3_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_cnt < char_len));
endmodule

// File: rtl/brk_char_counter.sv
// Down-counts the break characters still to send.
module brk_char_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  assign last = (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain <= '0;
    else if (load) remain <= load_val;
    else if (dec)  remain <= remain - CNT_W'(1);
  end

  // R2: a character never ends with nothing left to send
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (remain != '0));
endmodule

// File: rtl/brk_seq_tx.sv
module brk_seq_tx #(
  parameter int DLEN_W   = 4,
  parameter int MIN_DLEN = 5,
  parameter int MAX_DLEN = 14,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              stop_req,
  input  logic              tx_busy,
  input  logic              tx_data_in,
  input  logic [DLEN_W-1:0] data_len,
  input  logic              parity_en,
  input  logic              two_stop,
  input  logic [CNT_W-1:0]  brk_count,
  output logic              tx_line,
  output logic              tx_hold,
  output logic              brk_active,
  output logic              brk_done
);
  import brk_pkg::*;

  localparam int LEN_W = $clog2(MAX_DLEN + 5);

  brk_state_e       st_q;
  logic [LEN_W-1:0] len_w, len_q;
  logic             accept, char_end, last_char, done_q;

  assign accept = (st_q == ST_IDLE) && stop_req;

  brk_frame_len #(
    .DLEN_W(DLEN_W), .MIN_DLEN(MIN_DLEN), .MAX_DLEN(MAX_DLEN), .LEN_W(LEN_W)
  ) u_len (
    .data_len(data_len), .parity_en(parity_en), .two_stop(two_stop), .char_len(len_w)
  );

  brk_bit_timer #(.LEN_W(LEN_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_BREAK), .tick(bit_tick),
    .char_len(len_q), .char_end(char_end)
  );

  brk_char_counter #(.CNT_W(CNT_W)) u_chars (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(brk_count),
    .dec(char_end), .last(last_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= LEN_W'(MIN_DLEN + 2);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (stop_req) begin
          len_q <= len_w;
          if (brk_count == '0) done_q <= 1'b1;
          else                 st_q   <= ST_WAIT;
        end
        ST_WAIT:  if (bit_tick && !tx_busy) st_q <= ST_BREAK;
        ST_BREAK: if (char_end && last_char) st_q <= ST_GUARD;
        ST_GUARD: if (bit_tick) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_BREAK: tx_line = 1'b0;
      ST_GUARD: tx_line = 1'b1;
      default:  tx_line = tx_data_in;
    endcase
  end

  assign tx_hold    = (st_q != ST_IDLE);
  assign brk_active = (st_q == ST_BREAK) || (st_q == ST_GUARD);
  assign brk_done   = done_q;

  // R5: zero count finishes on the next cycle
  a_r5_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && st_q == ST_IDLE && brk_count == '0) |=> brk_done);
  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);
  // R6: the trailing bit is idle high
  a_r6_guard_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GUARD) |-> tx_line);
  // R4: no break starts while the transmitter is busy
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && tx_busy) |=> (st_q != ST_BREAK));
  // R8: a running break only proceeds to its idle bit
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BREAK) |=> (st_q == ST_BREAK || st_q == ST_GUARD));
  // R3: latched length stays inside the legal range
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BREAK) |-> (len_q >= LEN_W'(MIN_DLEN + 2) && len_q <= LEN_W'(MAX_DLEN + 4)));
endmodule

// File: tb/tb_brk_seq_tx.sv
module tb_brk_seq_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        stop_req = 1'b0;
  logic        tx_busy = 1'b0;
  logic        tx_data_in = 1'b1;
  logic [3:0]  data_len = 4'd8;
  logic        parity_en = 1'b0;
  logic        two_stop = 1'b0;
  logic [15:0] brk_count = 16'd0;
  logic        tx_line, tx_hold, brk_active, brk_done;

  int errors = 0;
  int checks = 0;
  int tick_period = 4;
  bit gen_on = 1'b0;

  always #10 clk = ~clk;

  brk_seq_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .stop_req(stop_req),
    .tx_busy(tx_busy), .tx_data_in(tx_data_in), .data_len(data_len),
    .parity_en(parity_en), .two_stop(two_stop), .brk_count(brk_count),
    .tx_line(tx_line), .tx_hold(tx_hold), .brk_active(brk_active), .brk_done(brk_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    wait (gen_on);
    forever begin
      repeat (tick_period - 1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  task automatic pulse_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic set_fmt(input int dl, input bit par, input bit two, input int cnt);
    data_len = 4'(dl); parity_en = par; two_stop = two; brk_count = 16'(cnt);
  endtask

  // Waits for the break, measures low run and idle gap, checks the end state.
  task automatic measure(input int exp_low, input int poke, input string req);
    int w = 0;
    int low = 0;
    int gap = 0;
    while (tx_line !== 1'b0 && w < 2000) begin @(negedge clk); w++; end
    chk(w < 2000, req, "break never started", w, 0);
    chk(brk_active === 1'b1 && tx_hold === 1'b1, "R2", "active/hold during break",
        int'(brk_active), 1);
    while (tx_line === 1'b0 && low < 5000) begin
      stop_req = (poke >= 0 && low == poke);
      @(negedge clk);
      low++;
    end
    stop_req = 1'b0;
    chk(low == exp_low, req, "low run cycles", low, exp_low);
    while (brk_done !== 1'b1 && gap < 2000) begin
      if (tx_line !== 1'b1) chk(1'b0, "R6", "line dropped in idle bit", int'(tx_line), 1);
      @(negedge clk);
      gap++;
    end
    chk(gap == tick_period, "R6", "cycles from line high to done", gap, tick_period);
    chk(tx_hold === 1'b0 && brk_active === 1'b0, "R6", "hold/active with done",
        int'(tx_hold) + int'(brk_active), 0);
    @(negedge clk);
    chk(brk_done === 1'b0, "R6", "done width", int'(brk_done), 0);
  endtask

  task automatic t_reset();
    chk(tx_line === 1'b1, "R1", "line after reset", int'(tx_line), 1);
    chk(tx_hold === 1'b0 && brk_active === 1'b0 && brk_done === 1'b0, "R1",
        "status after reset", int'(tx_hold) + int'(brk_active) + int'(brk_done), 0);
  endtask

  task automatic t_basic();
    set_fmt(8, 0, 0, 2);
    pulse_stop();
    measure(2 * 10 * tick_period, -1, "R2");
  endtask

  task automatic t_formats();
    set_fmt(5, 1, 1, 3);  pulse_stop(); measure(3 * 9 * tick_period, -1, "R3");
    set_fmt(14, 1, 1, 1); pulse_stop(); measure(1 * 18 * tick_period, -1, "R3");
    set_fmt(15, 0, 0, 1); pulse_stop(); measure(1 * 16 * tick_period, -1, "R3");
    set_fmt(2, 0, 0, 2);  pulse_stop(); measure(2 * 7 * tick_period, -1, "R3");
  endtask

  task automatic t_zero();
    bit low_seen = 1'b0;
    set_fmt(8, 0, 0, 0);
    pulse_stop();
    chk(brk_done === 1'b1, "R5", "done after zero-count stop", int'(brk_done), 1);
    @(negedge clk);
    chk(brk_done === 1'b0, "R5", "done width", int'(brk_done), 0);
    for (int i = 0; i < 12 * tick_period; i++) begin
      if (tx_line !== 1'b1 || brk_done !== 1'b0) low_seen = 1'b1;
      @(negedge clk);
    end
    chk(!low_seen, "R5", "line low or done again after zero count", int'(low_seen), 0);
  endtask

  task automatic t_busy();
    set_fmt(8, 0, 0, 1);
    tx_busy = 1'b1;
    tx_data_in = 1'b0;
    pulse_stop();
    repeat (3 * tick_period) @(negedge clk);
    chk(tx_hold === 1'b1, "R4", "hold while busy", int'(tx_hold), 1);
    chk(brk_active === 1'b0, "R4", "no break while busy", int'(brk_active), 0);
    chk(tx_line === 1'b0, "R4", "line follows data 0", int'(tx_line), 0);
    tx_data_in = 1'b1;
    @(negedge clk);
    chk(tx_line === 1'b1, "R4", "line follows data 1", int'(tx_line), 1);
    tx_busy = 1'b0;
    measure(10 * tick_period, -1, "R4");
  endtask

  task automatic t_capture();
    set_fmt(8, 0, 0, 2);
    pulse_stop();
    set_fmt(14, 1, 1, 5);
    measure(2 * 10 * tick_period, -1, "R7");
    set_fmt(8, 0, 0, 2);
  endtask

  task automatic t_retrigger();
    bit extra = 1'b0;
    set_fmt(8, 0, 0, 2);
    pulse_stop();
    measure(2 * 10 * tick_period, 5, "R8");
    for (int i = 0; i < 40 * tick_period; i++) begin
      if (tx_line !== 1'b1 || brk_done !== 1'b0) extra = 1'b1;
      @(negedge clk);
    end
    chk(!extra, "R8", "second break or done after ignored stop", int'(extra), 0);
  endtask

  task automatic t_tickrate();
    tick_period = 7;
    repeat (16) @(negedge clk);
    set_fmt(8, 0, 0, 1);
    pulse_stop();
    measure(10 * 7, -1, "R9");
    tick_period = 4;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    gen_on = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_formats();
    t_zero();
    t_busy();
    t_capture();
    t_retrigger();
    t_tickrate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule